// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sits beside a small 8-bit accumulator core and decides when the core leaves its current instruction stream to service an interrupt. It latches a vector of maskable request lines and a software trap request. It applies a global mask and selects one winner by fixed priority. At an instruction boundary it saves the core context one byte at a time through a stack port. It then sets the mask and hands the core the winning source's vector address.

When the core executes a return-from-interrupt, the block pops the saved context in reverse order and presents the rebuilt registers for one cycle. It clears the mask again. It also produces a wake signal for the core's low-power states: in wait, any serviceable pending request wakes the core. In halt, only sources that a parameter flags as external may wake it.

Top module: `irq_sequencer`

## Requirements
- R1: After reset the mask output is 1, push_valid and vec_valid are 0, and wake is 0.
- R2: A maskable request arriving while the mask is 1 is held pending and starts no entry. It is serviced at the first instruction boundary after the mask returns to 0.
- R3: An entry starts only from idle in a cycle where insn_end is 1. push_valid goes high in the next cycle, and with no insn_end no push occurs.
- R4: Entry pushes five bytes, one per cycle with push_valid and push_ready both 1, in this order: PC[15:8], PC[7:0], X, A, CC. While a beat is stalled, push_data holds steady.
- R5: vec_valid is a one-cycle pulse issued after the last push. The mask output is already 1 in that cycle.
- R6: The vector for maskable source i is bits [16i+15:16i] of VEC_TABLE, and the trap vector is TRAP_VEC. The winner's pending flag clears in the vector cycle, so a single pulse is serviced once.
- R7: A trap request is serviced at the next instruction boundary whether the mask is 0 or 1.
- R8: Among pending requests, the trap wins first, then source 0, then source 1, and so on upward.
- R9: On iret_req in idle, five bytes are popped, one per cycle with pop_req and pop_ack both 1, as CC, A, X, PC[7:0], PC[15:8]. rest_valid then pulses for one cycle with the rebuilt values, and the mask is 0 from the following cycle.
- R10: lp_mode encodes 0 as run, 1 as wait and 2 as halt. In run, wake is 0. In wait, wake is 1 when the trap is pending, or when any source is pending while the mask is 0. In halt, wake is 1 only when a source with its HALT_SRC bit set is pending while the mask is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_req | input | NUM_SRC | Maskable request lines, latched while high |
| trap_req | input | 1 | Software trap request, latched |
| insn_end | input | 1 | Instruction boundary strobe |
| iret_req | input | 1 | Return-from-interrupt request |
| lp_mode | input | 2 | Core power state: 0 run, 1 wait, 2 halt |
| ctx_pc | input | 16 | Core program counter to save |
| ctx_x | input | 8 | Index register to save |
| ctx_a | input | 8 | Accumulator to save |
| ctx_cc | input | 8 | Condition-code register to save |
| push_valid | output | 1 | Stack push byte valid |
| push_data | output | 8 | Stack push byte |
| push_ready | input | 1 | Stack accepts push byte |
| pop_req | output | 1 | Stack pop request |
| pop_data | input | 8 | Byte returned by stack |
| pop_ack | input | 1 | Pop byte valid |
| vec_valid | output | 1 | Vector issue pulse |
| vec_addr | output | 16 | Vector address for the program counter |
| rest_valid | output | 1 | Restored context valid pulse |
| rest_pc | output | 16 | Restored program counter |
| rest_x | output | 8 | Restored index register |
| rest_a | output | 8 | Restored accumulator |
| rest_cc | output | 8 | Restored condition codes |
| mask_o | output | 1 | Global interrupt mask |
| wake | output | 1 | Wake request to the core |

## Verification
The assertions assume that the stack side obeys the handshake: it never acknowledges a pop unless pop_req is high, and it drives push_ready and pop_ack from its own state. They also assume that insn_end and iret_req arrive only while the core is running its instruction stream, never in the middle of an entry or a return. The bench keeps to this by waiting for each vector pulse or restore pulse before it raises the next strobe. It models the stack as a LIFO whose ready pattern cycles every three clocks, so stalls land on every beat position.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    localparam int PC_W      = 16;
    localparam int BYTE_W    = 8;
    localparam int CTX_BYTES = 2 + 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH,
        ST_VEC,
        ST_POP,
        ST_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        LP_RUN  = 2'd0,
        LP_WAIT = 2'd1,
        LP_HALT = 2'd2
    } lp_mode_e;

    typedef struct packed {
        logic [PC_W-1:0]   pc;
        logic [BYTE_W-1:0] x;
        logic [BYTE_W-1:0] a;
        logic [BYTE_W-1:0] cc;
    } core_ctx_t;

endpackage

// File: rtl/irq_pending.sv
module irq_pending #(
    parameter int NUM_SRC = 4,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req,
    input  logic               trap_req,
    input  logic               clr_en,
    input  logic               clr_trap,
    input  logic [IDX_W-1:0]   clr_idx,
    output logic [NUM_SRC-1:0] pend,
    output logic               trap_pend
);

    logic [NUM_SRC-1:0] pend_d, pend_q, clr_vec;
    logic               trap_d, trap_q;

    // decode of the serviced source; a new request in the same cycle wins
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_clr
        assign clr_vec[i] = clr_en && !clr_trap && (clr_idx == IDX_W'(i));
    end

    always_comb begin
        pend_d = (pend_q & ~clr_vec) | req;
        trap_d = (trap_q & ~(clr_en & clr_trap)) | trap_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            trap_q <= 1'b0;
        end else begin
            pend_q <= pend_d;
            trap_q <= trap_d;
        end
    end

    assign pend      = pend_q;
    assign trap_pend = trap_q;

    // a latched request survives until its own vector is issued
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_hold
        assert_pend_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_q[i] && !clr_vec[i]) |=> pend_q[i]);
    end

    assert_trap_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_q && !(clr_en && clr_trap)) |=> trap_q);

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int NUM_SRC = 4,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] pend,
    input  logic               trap_pend,
    input  logic               mask,
    output logic               any_win,
    output logic               win_trap,
    output logic [IDX_W-1:0]   win_idx
);

    logic [NUM_SRC-1:0] cand, grant;
    logic [NUM_SRC:0]   blocked;

    assign cand       = mask ? '0 : pend;
    assign blocked[0] = trap_pend;

    // priority chain: lower index blocks every higher index
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_chain
        assign grant[i]     = cand[i] & ~blocked[i];
        assign blocked[i+1] = blocked[i] | cand[i];
    end

    always_comb begin
        win_idx = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (grant[i]) win_idx = win_idx | IDX_W'(i);
        end
    end

    assign win_trap = trap_pend;
    assign any_win  = blocked[NUM_SRC];

    assert_grant_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    assert_src0_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap_pend && !mask && pend[0]) |-> (any_win && win_idx == '0));

endmodule

// File: rtl/irq_wake.sv
module irq_wake
    import irq_seq_pkg::*;
#(
    parameter int                 NUM_SRC  = 4,
    parameter logic [NUM_SRC-1:0] HALT_SRC = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         lp_mode,
    input  logic [NUM_SRC-1:0] pend,
    input  logic               trap_pend,
    input  logic               mask,
    output logic               wake
);

    logic any_open, halt_open;

    assign any_open  = !mask && (|pend);
    assign halt_open = !mask && (|(pend & HALT_SRC));

    always_comb begin
        case (lp_mode)
            LP_WAIT: wake = trap_pend | any_open;
            LP_HALT: wake = halt_open;
            default: wake = 1'b0;
        endcase
    end

    assert_run_no_wake_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_mode == LP_RUN) |-> !wake);

    assert_masked_halt_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_mode == LP_HALT && mask) |-> !wake);

endmodule

// File: rtl/irq_sequencer.sv
module irq_sequencer
    import irq_seq_pkg::*;
#(
    parameter int                      NUM_SRC   = 4,
    parameter logic [NUM_SRC*16-1:0]   VEC_TABLE = 64'hFFF2_FFF4_FFF6_FFF8,
    parameter logic [15:0]             TRAP_VEC  = 16'hFFFA,
    parameter logic [NUM_SRC-1:0]      HALT_SRC  = 4'b0011
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic               trap_req,
    input  logic               insn_end,
    input  logic               iret_req,
    input  logic [1:0]         lp_mode,
    input  logic [15:0]        ctx_pc,
    input  logic [7:0]         ctx_x,
    input  logic [7:0]         ctx_a,
    input  logic [7:0]         ctx_cc,
    output logic               push_valid,
    output logic [7:0]         push_data,
    input  logic               push_ready,
    output logic               pop_req,
    input  logic [7:0]         pop_data,
    input  logic               pop_ack,
    output logic               vec_valid,
    output logic [15:0]        vec_addr,
    output logic               rest_valid,
    output logic [15:0]        rest_pc,
    output logic [7:0]         rest_x,
    output logic [7:0]         rest_a,
    output logic [7:0]         rest_cc,
    output logic               mask_o,
    output logic               wake
);

    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int BEAT_W = $clog2(CTX_BYTES);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(CTX_BYTES - 1);

    typedef struct packed {
        seq_state_e         st;
        logic [BEAT_W-1:0]  beat;
        logic               mask;
        logic               sel_trap;
        logic [IDX_W-1:0]   sel_idx;
        core_ctx_t          ctx;
    } seq_reg_t;

    seq_reg_t r_d, r_q;

    logic [NUM_SRC-1:0] pend;
    logic               trap_pend;
    logic               any_win, win_trap;
    logic [IDX_W-1:0]   win_idx;
    logic               clr_en;

    irq_pending #(.NUM_SRC(NUM_SRC)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (irq_req),
        .trap_req (trap_req),
        .clr_en   (clr_en),
        .clr_trap (r_q.sel_trap),
        .clr_idx  (r_q.sel_idx),
        .pend     (pend),
        .trap_pend(trap_pend)
    );

    irq_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend     (pend),
        .trap_pend(trap_pend),
        .mask     (r_q.mask),
        .any_win  (any_win),
        .win_trap (win_trap),
        .win_idx  (win_idx)
    );

    irq_wake #(.NUM_SRC(NUM_SRC), .HALT_SRC(HALT_SRC)) u_wake (
        .clk      (clk),
        .rst_n    (rst_n),
        .lp_mode  (lp_mode),
        .pend     (pend),
        .trap_pend(trap_pend),
        .mask     (r_q.mask),
        .wake     (wake)
    );

    always_comb begin
        r_d        = r_q;
        push_valid = 1'b0;
        push_data  = '0;
        pop_req    = 1'b0;
        vec_valid  = 1'b0;
        rest_valid = 1'b0;
        clr_en     = 1'b0;

        case (r_q.st)
            ST_IDLE: begin
                if (iret_req) begin
                    r_d.st   = ST_POP;
                    r_d.beat = '0;
                end else if (insn_end && any_win) begin
                    r_d.st       = ST_PUSH;
                    r_d.beat     = '0;
                    r_d.sel_trap = win_trap;
                    r_d.sel_idx  = win_idx;
                    r_d.ctx      = '{pc: ctx_pc, x: ctx_x, a: ctx_a, cc: ctx_cc};
                end
            end
            ST_PUSH: begin
                push_valid = 1'b1;
                case (r_q.beat)
                    BEAT_W'(0): push_data = r_q.ctx.pc[15:8];
                    BEAT_W'(1): push_data = r_q.ctx.pc[7:0];
                    BEAT_W'(2): push_data = r_q.ctx.x;
                    BEAT_W'(3): push_data = r_q.ctx.a;
                    default:    push_data = r_q.ctx.cc;
                endcase
                if (push_ready) begin
                    if (r_q.beat == LAST_BEAT) begin
                        r_d.st   = ST_VEC;
                        r_d.mask = 1'b1;
                    end else begin
                        r_d.beat = r_q.beat + 1'b1;
                    end
                end
            end
            ST_VEC: begin
                vec_valid = 1'b1;
                clr_en    = 1'b1;
                r_d.st    = ST_IDLE;
            end
            ST_POP: begin
                pop_req = 1'b1;
                if (pop_ack) begin
                    case (r_q.beat)
                        BEAT_W'(0): r_d.ctx.cc       = pop_data;
                        BEAT_W'(1): r_d.ctx.a        = pop_data;
                        BEAT_W'(2): r_d.ctx.x        = pop_data;
                        BEAT_W'(3): r_d.ctx.pc[7:0]  = pop_data;
                        default:    r_d.ctx.pc[15:8] = pop_data;
                    endcase
                    if (r_q.beat == LAST_BEAT) r_d.st = ST_DONE;
                    else                       r_d.beat = r_q.beat + 1'b1;
                end
            end
            ST_DONE: begin
                rest_valid = 1'b1;
                r_d.mask   = 1'b0;
                r_d.st     = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.st       <= ST_IDLE;
            r_q.mask     <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign vec_addr = r_q.sel_trap ? TRAP_VEC : VEC_TABLE[r_q.sel_idx*16 +: 16];
    assign rest_pc  = r_q.ctx.pc;
    assign rest_x   = r_q.ctx.x;
    assign rest_a   = r_q.ctx.a;
    assign rest_cc  = r_q.ctx.cc;
    assign mask_o   = r_q.mask;

    assert_entry_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(push_valid) |-> $past(insn_end));

    assert_push_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && !push_ready) |=> (push_valid && $stable(push_data)));

    assert_vec_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> mask_o);

    assert_vec_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid);

    assert_iret_unmask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rest_valid |=> !mask_o);

endmodule

// File: tb/sim_irq_sequencer.sv
`timescale 1ns/1ps
module sim_irq_sequencer;

    localparam logic [15:0] TRAP_V = 16'hFFFA;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  irq_req = '0;
    logic        trap_req = 1'b0, insn_end = 1'b0, iret_req = 1'b0;
    logic [1:0]  lp_mode = 2'd0;
    logic [15:0] ctx_pc = '0;
    logic [7:0]  ctx_x = '0, ctx_a = '0, ctx_cc = '0;
    logic        push_valid, push_ready, pop_req, pop_ack;
    logic [7:0]  push_data, pop_data;
    logic        vec_valid, rest_valid, mask_o, wake;
    logic [15:0] vec_addr, rest_pc;
    logic [7:0]  rest_x, rest_a, rest_cc;

    int nvec = 0, nfail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    // LIFO stack model with a ready pattern that stalls one cycle in three
    logic [7:0] stk [0:63];
    int         sp = 0;
    int         rdy_ctr = 0;
    always @(negedge clk) rdy_ctr <= rdy_ctr + 1;
    assign push_ready = (rdy_ctr % 3) != 0;
    assign pop_ack    = pop_req && ((rdy_ctr % 3) != 1);
    assign pop_data   = (sp > 0) ? stk[sp-1] : 8'h00;
    always @(posedge clk) begin
        if (push_valid && push_ready) begin
            stk[sp] <= push_data;
            sp      <= sp + 1;
        end else if (pop_req && pop_ack) begin
            sp <= sp - 1;
        end
    end

    irq_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .trap_req(trap_req),
        .insn_end(insn_end), .iret_req(iret_req), .lp_mode(lp_mode),
        .ctx_pc(ctx_pc), .ctx_x(ctx_x), .ctx_a(ctx_a), .ctx_cc(ctx_cc),
        .push_valid(push_valid), .push_data(push_data), .push_ready(push_ready),
        .pop_req(pop_req), .pop_data(pop_data), .pop_ack(pop_ack),
        .vec_valid(vec_valid), .vec_addr(vec_addr), .rest_valid(rest_valid),
        .rest_pc(rest_pc), .rest_x(rest_x), .rest_a(rest_a), .rest_cc(rest_cc),
        .mask_o(mask_o), .wake(wake)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] k_pc(input int k); return 16'h1234 + 16'(k * 257); endfunction
    function automatic logic [7:0]  k_x (input int k); return 8'(k);                   endfunction
    function automatic logic [7:0]  k_a (input int k); return ~8'(k);                  endfunction
    function automatic logic [7:0]  k_cc(input int k); return 8'(k) ^ 8'h5A;           endfunction

    task automatic pulse_req(input logic [3:0] s, input bit t);
        @(negedge clk);
        irq_req  = s;
        trap_req = t;
        @(negedge clk);
        irq_req  = '0;
        trap_req = 1'b0;
    endtask

    task automatic do_entry(input logic [15:0] exp_vec, input string req, input int k);
        int  sp0;
        bit  got;
        logic [15:0] v;
        @(negedge clk);
        ctx_pc = k_pc(k); ctx_x = k_x(k); ctx_a = k_a(k); ctx_cc = k_cc(k);
        sp0 = sp;
        insn_end = 1'b1;
        @(negedge clk);
        insn_end = 1'b0;
        chk(push_valid === 1'b1, "R3 entry starts after insn_end", 32'(push_valid), 1);
        got = 1'b0;
        v   = '0;
        for (int c = 0; c < 40 && !got; c++) begin
            if (vec_valid) begin
                got = 1'b1;
                v   = vec_addr;
                chk(mask_o === 1'b1, "R5 mask set at vector", 32'(mask_o), 1);
            end else begin
                @(negedge clk);
            end
        end
        chk(got, "R5 vector issued", 32'(got), 1);
        chk(v === exp_vec, req, 32'(v), 32'(exp_vec));
        chk(sp == sp0 + 5, "R4 five bytes pushed", 32'(sp - sp0), 5);
        if (sp >= 5) begin
            chk(stk[sp-5] === k_pc(k)[15:8], "R4 byte0 PC high", 32'(stk[sp-5]), 32'(k_pc(k)[15:8]));
            chk(stk[sp-4] === k_pc(k)[7:0],  "R4 byte1 PC low",  32'(stk[sp-4]), 32'(k_pc(k)[7:0]));
            chk(stk[sp-3] === k_x(k),        "R4 byte2 X",       32'(stk[sp-3]), 32'(k_x(k)));
            chk(stk[sp-2] === k_a(k),        "R4 byte3 A",       32'(stk[sp-2]), 32'(k_a(k)));
            chk(stk[sp-1] === k_cc(k),       "R4 byte4 CC",      32'(stk[sp-1]), 32'(k_cc(k)));
        end
    endtask

    task automatic do_iret(input int k);
        bit got;
        @(negedge clk);
        iret_req = 1'b1;
        @(negedge clk);
        iret_req = 1'b0;
        got = 1'b0;
        for (int c = 0; c < 40 && !got; c++) begin
            if (rest_valid) begin
                got = 1'b1;
                chk(rest_pc === k_pc(k), "R9 restored PC", 32'(rest_pc), 32'(k_pc(k)));
                chk(rest_x  === k_x(k),  "R9 restored X",  32'(rest_x),  32'(k_x(k)));
                chk(rest_a  === k_a(k),  "R9 restored A",  32'(rest_a),  32'(k_a(k)));
                chk(rest_cc === k_cc(k), "R9 restored CC", 32'(rest_cc), 32'(k_cc(k)));
            end
            @(negedge clk);
        end
        chk(got, "R9 restore pulse", 32'(got), 1);
        chk(mask_o === 1'b0, "R9 mask clear after return", 32'(mask_o), 0);
    endtask

    task automatic chk_wake(input logic [1:0] m, input bit exp, input string req);
        lp_mode = m;
        #0.5;
        chk(wake === exp, req, 32'(wake), 32'(exp));
        lp_mode = 2'd0;
    endtask

    initial begin
        int k = 1;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(mask_o === 1'b1,     "R1 mask after reset",   32'(mask_o), 1);
        chk(push_valid === 1'b0, "R1 no push in reset",   32'(push_valid), 0);
        chk(vec_valid === 1'b0,  "R1 no vector in reset", 32'(vec_valid), 0);
        chk(wake === 1'b0,       "R1 wake low in reset",  32'(wake), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mask_o === 1'b1, "R1 mask set after reset release", 32'(mask_o), 1);

        // R2 masked request latched, no entry
        pulse_req(4'b0100, 1'b0);
        chk_wake(2'd1, 1'b0, "R10 wait wake blocked by mask");
        insn_end = 1'b1;
        @(negedge clk);
        insn_end = 1'b0;
        for (int c = 0; c < 6; c++) begin
            chk(push_valid === 1'b0, "R2 masked request starts no entry", 32'(push_valid), 0);
            @(negedge clk);
        end

        // R7 trap while masked
        pulse_req(4'b0000, 1'b1);
        do_entry(TRAP_V, "R7 trap vector under mask", k);
        do_iret(k);
        k++;
        chk_wake(2'd1, 1'b1, "R10 wait wakes on pending source 2");
        chk_wake(2'd2, 1'b0, "R10 halt ignores source 2");
        chk_wake(2'd0, 1'b0, "R10 run never wakes");
        do_entry(16'hFFF4, "R2 latched source 2 serviced", k);
        do_iret(k);
        k++;

        // R3 no insn_end, no entry
        pulse_req(4'b0001, 1'b0);
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            chk(push_valid === 1'b0, "R3 no entry without insn_end", 32'(push_valid), 0);
        end
        do_entry(16'hFFF8, "R6 source 0 vector", k);
        do_iret(k);
        k++;

        // R8 trap beats source 0
        pulse_req(4'b0001, 1'b1);
        chk_wake(2'd1, 1'b1, "R10 wait wakes on trap");
        do_entry(TRAP_V, "R8 trap before source 0", k);
        do_iret(k);
        k++;
        do_entry(16'hFFF8, "R8 source 0 after trap", k);
        do_iret(k);
        k++;

        // sweep every subset of sources
        for (int s = 1; s < 16; s++) begin
            logic [3:0] rem;
            rem = 4'(s);
            pulse_req(rem, 1'b0);
            chk_wake(2'd0, 1'b0, "R10 run sweep");
            chk_wake(2'd1, 1'b1, "R10 wait sweep");
            chk_wake(2'd2, |(rem & 4'b0011), "R10 halt sweep");
            while (rem != 0) begin
                int lo;
                lo = 0;
                for (int b = 3; b >= 0; b--) if (rem[b]) lo = b;
                do_entry(16'hFFF8 - 16'(2 * lo), "R8 R6 priority sweep vector", k);
                do_iret(k);
                k++;
                rem[lo] = 1'b0;
            end
            chk(wake === 1'b0, "R6 pending cleared after service", 32'(wake), 0);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

endmodule